// File: doc/BRIEF.md
# Fully Associative Translation Cache with Address-Space Tags

This block holds a small set of virtual-to-physical page translations and answers one lookup per cycle. A request carries a virtual address, the identifier of the running address space and an access kind. Every slot is compared against the request at once, and any slot may hold any translation. One cycle later the block reports exactly one of three outcomes. It can return a translated physical address. It can report that no matching translation is present. It can report that a translation matched but the requested access is not permitted.

New translations arrive on a separate insert port. This port fills free slots first, overwrites a slot that already holds the same page and address space, and otherwise evicts a victim. A parameter chooses whether the victim is the least recently used slot or one picked by a pseudo-random sequence. A flush input drops every translation in one cycle, for use when address spaces are switched without identifier tags. The page walk that fetches missing translations lies outside the block.

Top module: `asid_tlb`

## Requirements
- R1: Each cycle with `req_valid` high produces, on the next cycle, `rsp_valid` high with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` high. A cycle without a request gives `rsp_valid` and all three outcome flags low on the next cycle.
- R2: The page number is `req_va >> PAGE_BITS`. On a hit, `rsp_pa` equals the stored frame number shifted left by `PAGE_BITS`, ORed with the unchanged low `PAGE_BITS` bits of `req_va`.
- R3: A slot matches only when it is valid, its page number equals the request page number and its address-space tag equals `req_asid`. The same page number under two tags can be held at the same time, with different frames.
- R4: Permission bits are bit 0 read, bit 1 write and bit 2 execute. The access code is 0 read, 1 write, 2 execute, and 3 is never permitted. A matching slot that lacks the requested permission gives `rsp_fault` with `rsp_pa` zero.
- R5: A flush clears every slot's valid bit, so later lookups of any previously held page miss.
- R6: When flush and insert occur in the same cycle, the flush applies first and the inserted translation stays valid.
- R7: An insert that does not duplicate a held translation goes to the lowest-numbered invalid slot. No valid translation is evicted while a slot is free.
- R8: An insert whose page number and tag equal those of a valid slot overwrites that slot (frame and permissions) and creates no second copy.
- R9: With `REPL_LRU` set, an insert into a full table evicts the slot least recently used. A slot counts as used when it is written or when it produces a hit. When an insert and a hit occur in the same cycle, only the insert counts as a use. With `REPL_LRU` clear, the victim is taken from a free-running pseudo-random sequence.
- R10: After reset every slot is invalid and all response outputs are low.
- R11: A lookup sees the table as it was before any insert or flush of the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all slots |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | VA_W | Virtual address to translate |
| req_asid | input | ASID_W | Current address-space tag |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| ins_valid | input | 1 | Insert strobe |
| ins_vpn | input | VA_W-PAGE_BITS | Page number to insert |
| ins_asid | input | ASID_W | Address-space tag to insert |
| ins_pfn | input | PA_W-PAGE_BITS | Frame number to insert |
| ins_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching slot |
| rsp_fault | output | 1 | Matching slot forbids the access |
| rsp_pa | output | PA_W | Physical address on hit, else zero |

## Verification
The embedded properties check the following on every cycle: the one-cycle response timing and the single outcome, that a hit passes the page offset through unchanged, that a fault carries a zero address, that at most one slot ever matches a request, and the slot state left by a flush with or without a same-cycle insert. The bench scenarios are needed for the rest. They cover the frame numbers that come back under different tags and access kinds, and the lowest-free fill order, which they show by filling the table without losing an entry. They also cover the victim chosen by recency, the overwrite of a duplicate, and a lookup that still hits while a flush is in progress.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ASID_W    = 8,
  parameter bit REPL_LRU  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_va,
  input  logic [ASID_W-1:0]         req_asid,
  input  logic [1:0]                req_acc,
  input  logic                      ins_valid,
  input  logic [VA_W-PAGE_BITS-1:0] ins_vpn,
  input  logic [ASID_W-1:0]         ins_asid,
  input  logic [PA_W-PAGE_BITS-1:0] ins_pfn,
  input  logic [2:0]                ins_perm,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic                      rsp_miss,
  output logic                      rsp_fault,
  output logic [PA_W-1:0]           rsp_pa
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag_vpn  [ENTRIES];
  logic [ASID_W-1:0]  tag_asid [ENTRIES];
  logic [PFN_W-1:0]   slot_pfn [ENTRIES];
  logic [2:0]         slot_perm[ENTRIES];

  wire [VPN_W-1:0] req_vpn = req_va[VA_W-1:PAGE_BITS];

  logic [ENTRIES-1:0] match, dup;
  logic [PFN_W-1:0]   hit_pfn;
  logic [2:0]         hit_perm;
  logic [IDX_W-1:0]   hit_idx;

  always_comb begin
    hit_pfn  = '0;
    hit_perm = '0;
    hit_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = vld[i] && tag_vpn[i] == req_vpn && tag_asid[i] == req_asid;
      dup[i]   = vld[i] && tag_vpn[i] == ins_vpn && tag_asid[i] == ins_asid;
      if (match[i]) begin
        hit_pfn  = hit_pfn | slot_pfn[i];
        hit_perm = hit_perm | slot_perm[i];
        hit_idx  = IDX_W'(i);
      end
    end
  end

  logic allowed;
  always_comb begin
    case (req_acc)
      2'd0:    allowed = hit_perm[0];
      2'd1:    allowed = hit_perm[1];
      2'd2:    allowed = hit_perm[2];
      default: allowed = 1'b0;
    endcase
  end

  wire any_match = |match;
  wire good_hit  = req_valid && any_match && allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= good_hit;
      rsp_miss  <= req_valid && !any_match;
      rsp_fault <= req_valid && any_match && !allowed;
      rsp_pa    <= good_hit ? {hit_pfn, req_va[PAGE_BITS-1:0]} : '0;
    end
  end

  logic [IDX_W-1:0] victim, ins_idx;
  always_comb begin
    logic found_free, found_dup;
    logic [IDX_W-1:0] free_idx, dup_idx;
    found_free = 1'b0;
    found_dup  = 1'b0;
    free_idx   = '0;
    dup_idx    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        found_free = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (dup[i]) begin
        found_dup = 1'b1;
        dup_idx   = IDX_W'(i);
      end
    end
    if (flush)           ins_idx = '0;
    else if (found_dup)  ins_idx = dup_idx;
    else if (found_free) ins_idx = free_idx;
    else                 ins_idx = victim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else begin
      if (flush) vld <= '0;
      if (ins_valid) vld[ins_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid) begin
      tag_vpn[ins_idx]   <= ins_vpn;
      tag_asid[ins_idx]  <= ins_asid;
      slot_pfn[ins_idx]  <= ins_pfn;
      slot_perm[ins_idx] <= ins_perm;
    end
  end

  generate
    if (REPL_LRU) begin : g_lru
      logic [IDX_W-1:0] age [ENTRIES];
      wire              touch     = ins_valid || good_hit;
      wire [IDX_W-1:0]  touch_idx = ins_valid ? ins_idx : hit_idx;

      always_comb begin
        victim = '0;
        for (int i = 0; i < ENTRIES; i++)
          if (age[i] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(i);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
        end else if (touch) begin
          for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == touch_idx)      age[i] <= '0;
            else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
          end
        end
      end
    end else begin : g_rand
      logic [15:0] lfsr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr <= 16'hACE1;
        else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
      assign victim = IDX_W'(32'(lfsr) % ENTRIES);
    end
  endgenerate

  assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_is_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault);
  assert_single_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  assert_offset_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_pa[PAGE_BITS-1:0] == $past(req_va[PAGE_BITS-1:0]));
  assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_pa == '0);
  assert_unique_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match) <= 1);
  assert_flush_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !ins_valid |=> vld == '0);
  assert_flush_then_insert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush && ins_valid |=> vld == ENTRIES'(1));
endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int VW = 32;
  localparam int PW = 32;
  localparam int PB = 12;
  localparam int AW = 8;
  localparam logic [1:0] K_HIT = 2'd0, K_MISS = 2'd1, K_FAULT = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic req_valid = 1'b0, ins_valid = 1'b0;
  logic [VW-1:0] req_va = '0;
  logic [AW-1:0] req_asid = '0, ins_asid = '0;
  logic [1:0] req_acc = '0;
  logic [VW-PB-1:0] ins_vpn = '0;
  logic [PW-PB-1:0] ins_pfn = '0;
  logic [2:0] ins_perm = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [PW-1:0] rsp_pa;

  int checks = 0, errors = 0;
  logic [1:0]  got_kind;
  logic [31:0] got_pa;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb #(.ENTRIES(N), .VA_W(VW), .PA_W(PW), .PAGE_BITS(PB), .ASID_W(AW), .REPL_LRU(1'b1)) i_asid_tlb (
    .clk, .rst_n, .flush, .req_valid, .req_va, .req_asid, .req_acc,
    .ins_valid, .ins_vpn, .ins_asid, .ins_pfn, .ins_perm,
    .rsp_valid, .rsp_hit, .rsp_miss, .rsp_fault, .rsp_pa);

  // {va, asid, acc, kind, pa}
  localparam int VEC_N = 8;
  localparam logic [75:0] VEC [VEC_N] = '{
    {32'h0001_0123, 8'd1, 2'd0, K_HIT,   32'h0010_0123},
    {32'h0001_0FFF, 8'd2, 2'd0, K_HIT,   32'h0017_0FFF},
    {32'h0001_0004, 8'd2, 2'd1, K_FAULT, 32'h0},
    {32'h0002_0010, 8'd1, 2'd2, K_HIT,   32'h00AB_C010},
    {32'h0002_0010, 8'd1, 2'd0, K_FAULT, 32'h0},
    {32'h0002_0010, 8'd2, 2'd2, K_MISS,  32'h0},
    {32'h0003_0000, 8'd1, 2'd0, K_MISS,  32'h0},
    {32'h0001_0800, 8'd1, 2'd3, K_FAULT, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_asid = asid; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    got_kind = !rsp_valid ? 2'd3 : rsp_hit ? K_HIT : rsp_miss ? K_MISS : rsp_fault ? K_FAULT : 2'd3;
    got_pa = rsp_pa;
  endtask

  task automatic insert(input logic [19:0] vpn, input logic [7:0] asid,
                        input logic [19:0] pfn, input logic [2:0] perm, input logic fl);
    @(negedge clk);
    ins_valid = 1'b1; ins_vpn = vpn; ins_asid = asid; ins_pfn = pfn; ins_perm = perm; flush = fl;
    @(negedge clk);
    ins_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [19:0] vpn, input logic [19:0] pfn);
    lookup({vpn, 12'h5A5}, 8'd0, 2'd0);
    check(req, {30'd0, got_kind}, {30'd0, K_HIT});
    check(req, got_pa, {pfn, 12'h5A5});
  endtask

  task automatic expect_miss(input string req, input logic [19:0] vpn);
    lookup({vpn, 12'h000}, 8'd0, 2'd0);
    check(req, {30'd0, got_kind}, {30'd0, K_MISS});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'd0);
    check("R10 reset pa", rsp_pa, 32'd0);
    rst_n = 1'b1;
    lookup(32'h0001_0000, 8'd1, 2'd0);
    check("R10 empty after reset", {30'd0, got_kind}, {30'd0, K_MISS});
    @(negedge clk);
    check("R1 idle no response", {31'd0, rsp_valid}, 32'd0);

    insert(20'h00010, 8'd1, 20'h00100, 3'b111, 1'b0);
    insert(20'h00010, 8'd2, 20'h00170, 3'b001, 1'b0);
    insert(20'h00020, 8'd1, 20'h00ABC, 3'b100, 1'b0);
    for (int v = 0; v < VEC_N; v++) begin
      lookup(VEC[v][75:44], VEC[v][43:36], VEC[v][35:34]);
      check($sformatf("R1 R2 R3 R4 vector %0d kind", v), {30'd0, got_kind}, {30'd0, VEC[v][33:32]});
      check($sformatf("R2 R4 vector %0d pa", v), got_pa, VEC[v][31:0]);
    end

    insert(20'h0, 8'd0, 20'h0, 3'b000, 1'b1);
    expect_miss("R5 flush clears", 20'h00010);
    insert(20'h00001, 8'd0, 20'h00A01, 3'b001, 1'b0);
    insert(20'h00002, 8'd0, 20'h00A02, 3'b001, 1'b0);
    insert(20'h00003, 8'd0, 20'h00A03, 3'b001, 1'b0);
    insert(20'h00004, 8'd0, 20'h00A04, 3'b001, 1'b0);
    expect_hit("R7 fill keeps 1", 20'h00001, 20'h00A01);
    expect_hit("R7 fill keeps 2", 20'h00002, 20'h00A02);
    expect_hit("R7 fill keeps 3", 20'h00003, 20'h00A03);
    expect_hit("R7 fill keeps 4", 20'h00004, 20'h00A04);
    // recency now oldest->newest: 1,2,3,4; touch 1 so 2 is oldest
    expect_hit("R9 touch 1", 20'h00001, 20'h00A01);
    insert(20'h00005, 8'd0, 20'h00A05, 3'b001, 1'b0);
    expect_miss("R9 lru evicted 2", 20'h00002);
    expect_hit("R9 kept 1", 20'h00001, 20'h00A01);
    expect_hit("R9 kept 3", 20'h00003, 20'h00A03);
    expect_hit("R9 kept 4", 20'h00004, 20'h00A04);
    expect_hit("R9 new 5", 20'h00005, 20'h00A05);

    insert(20'h00003, 8'd0, 20'h00B03, 3'b001, 1'b0);
    expect_hit("R8 overwrite 3", 20'h00003, 20'h00B03);
    expect_hit("R8 kept 1", 20'h00001, 20'h00A01);
    expect_hit("R8 kept 4", 20'h00004, 20'h00A04);
    expect_hit("R8 kept 5", 20'h00005, 20'h00A05);

    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h0000_1111; req_asid = 8'd0; req_acc = 2'd0; flush = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0;
    check("R11 lookup during flush hits", {31'd0, rsp_hit}, 32'd1);
    check("R11 lookup during flush pa", rsp_pa, 32'h00A0_1111);
    expect_miss("R5 after flush 1", 20'h00001);
    expect_miss("R5 after flush 5", 20'h00005);

    insert(20'h00001, 8'd0, 20'h00A01, 3'b001, 1'b0);
    insert(20'h00009, 8'd0, 20'h00A09, 3'b001, 1'b1);
    expect_hit("R6 insert survives flush", 20'h00009, 20'h00A09);
    expect_miss("R6 older entry flushed", 20'h00001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule